// File: doc/BRIEF.md
# Tile-Based Banked Texture Cache

This block is a read-only cache for a texture sampler. It stores 32-bit texels as whole 4x4 tiles, one tile per line. A lookup gives the integer texel coordinate of the top-left corner of a 2x2 footprint. The cache returns the four texels that bilinear filtering needs, all in one response. Each line is split into four banks of four texels. Texels are spread across the banks so that any 2x2 footprint lands in four different banks. A footprint that sits inside one resident tile is therefore read in a single access.

A footprint that crosses a tile edge in x, in y or in both touches two or four tiles. The cache visits those tiles one at a time, in a fixed order, and collects the texels that belong to each. When a tile is not resident, the lookup stalls. The cache sends a tile fill request to an external memory port, writes the 16 returned texels into the line, updates the tag, and then replays the access. Both the lookup side and the fill request side use valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. A sender holds its valid and payload until that edge, and a receiver may hold ready low for as long as it likes. The fill data return is a plain valid strobe that cannot be stalled. A single invalidate pin discards every resident tile.

Top module: `tex_tile_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and fill_req_valid is 0, and no tile is resident.
- R2: A lookup at (x, y) returns four lanes in rsp_texels. Lane i occupies bits [32*i+31 : 32*i] and holds the texel at (x + i%2, y + i/2). Each coordinate wraps modulo 2^COORD_W.
- R3: The tile coordinate is the texel coordinate shifted right by 2. The cache is direct-mapped. The line index is {tile_y[1:0], tile_x[2:0]} and the tag is the remaining tile bits. A tile with the same index but a different tag evicts the resident one.
- R4: On a miss, fill_req_valid rises with fill_tile_x/fill_tile_y, and both are held until fill_req_ready. The cache then accepts 16 beats on fill_data_valid in raster order within the tile: beat k is column k%4, row k/4. Idle cycles between beats are allowed.
- R5: A lookup whose tiles are all resident issues no fill request.
- R6: A footprint spanning several tiles is serviced one tile at a time. The order is the tiles of lane 0, lane 1, lane 2 and lane 3, with repeated tiles skipped. Missing tiles are fetched in that same order. rsp_valid rises only after all four lanes have been collected.
- R7: When all n distinct tiles of a footprint (n = 1, 2 or 4) are resident, rsp_valid is high after the (n+1)-th rising edge, counting the edge that accepts the request as the first.
- R8: req_ready is low from the accepting edge until the edge that takes the response, so only one lookup is in flight at a time.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_texels hold their values.
- R10: A cycle with invalidate high makes every line non-resident from the next edge on, so a later lookup fetches again. Invalidate takes priority over a fill that completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| invalidate | input | 1 | Discard all resident tiles |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Cache can accept a lookup |
| req_x | input | COORD_W | Footprint top-left texel x |
| req_y | input | COORD_W | Footprint top-left texel y |
| rsp_valid | output | 1 | Footprint texels valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_texels | output | 4*TEXEL_W | Four texels, lane i in bits [TEXEL_W*i +: TEXEL_W] |
| fill_req_valid | output | 1 | Tile fill request valid |
| fill_req_ready | input | 1 | Memory accepts the fill request |
| fill_tile_x | output | COORD_W-2 | Tile x coordinate to fetch |
| fill_tile_y | output | COORD_W-2 | Tile y coordinate to fetch |
| fill_data_valid | input | 1 | Fill beat valid |
| fill_data | input | TEXEL_W | Fill texel, raster order in tile |

## Verification
Four kinds of footprint are driven: one that stays inside a tile, one that crosses an edge in x only, one that crosses in both x and y, and one at the texture corner whose neighbours wrap to coordinate zero. Together they separate bank and lane steering errors from tile-order and wrap errors. The same footprints are repeated once their tiles are resident. Counting fill requests and measuring the response latency then tells a genuine hit from a silent refetch. An index conflict, a refetch after invalidate, and a response held under back-pressure cover eviction, clearing and stall behaviour.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int TILE_DIM  = 4;
  localparam int NUM_BANKS = 4;
  localparam int BANK_DEPTH = 4;
  localparam int TILE_TEXELS = TILE_DIM * TILE_DIM;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_FREQ,
    ST_FDATA,
    ST_RESP
  } tc_state_e;

  // bank chosen by the parity of the in-tile column and row
  function automatic logic [1:0] bank_sel(input logic [1:0] col, input logic [1:0] row);
    return {row[0], col[0]};
  endfunction

  // position of a texel inside its bank: which 2x2 quadrant of the tile
  function automatic logic [1:0] slot_sel(input logic [1:0] col, input logic [1:0] row);
    return {row[1], col[1]};
  endfunction

endpackage

// File: rtl/tc_tag_store.sv
module tc_tag_store #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5,
  parameter int TAG_W     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inval_i,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);

  logic [NUM_LINES-1:0] vld_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (inval_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
    end
  end

  assign lk_hit_o = vld_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);

  // R10: a cycle of invalidate leaves no line resident
  a_r10_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> (vld_q == '0));

  // R1: nothing is resident right after reset
  a_r1_empty_after_reset: assert property (@(posedge clk)
    !rst_n |=> (vld_q == '0));

endmodule

// File: rtl/tc_bank_store.sv
module tc_bank_store
  import tc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5,
  parameter int TEXEL_W   = 32
) (
  input  logic                              clk,
  input  logic [IDX_W-1:0]                  rd_idx_i,
  input  logic [NUM_BANKS-1:0][1:0]         rd_slot_i,
  output logic [NUM_BANKS-1:0][TEXEL_W-1:0] rd_data_o,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [1:0]                        wr_bank_i,
  input  logic [1:0]                        wr_slot_i,
  input  logic [TEXEL_W-1:0]                wr_data_i
);

  localparam int ADDR_W = IDX_W + 2;
  localparam int DEPTH  = NUM_LINES * BANK_DEPTH;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TEXEL_W-1:0] mem_q [DEPTH];
    logic               we;

    assign we = wr_en_i && (wr_bank_i == 2'(b));

    always_ff @(posedge clk) begin
      if (we) begin
        mem_q[ADDR_W'({wr_idx_i, wr_slot_i})] <= wr_data_i;
      end
    end

    assign rd_data_o[b] = mem_q[ADDR_W'({rd_idx_i, rd_slot_i[b]})];
  end

endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int TEXEL_W = 32,
  parameter int COORD_W = 12,
  parameter int IDX_X_W = 3,
  parameter int IDX_Y_W = 2,
  parameter int TC_W    = COORD_W - 2,
  parameter int IDX_W   = IDX_X_W + IDX_Y_W,
  parameter int TAG_W   = 2 * TC_W - IDX_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [COORD_W-1:0]                req_x,
  input  logic [COORD_W-1:0]                req_y,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [NUM_BANKS*TEXEL_W-1:0]      rsp_texels,
  output logic                              fill_req_valid,
  input  logic                              fill_req_ready,
  output logic [TC_W-1:0]                   fill_tile_x,
  output logic [TC_W-1:0]                   fill_tile_y,
  input  logic                              fill_data_valid,
  output logic [IDX_W-1:0]                  lk_idx,
  output logic [TAG_W-1:0]                  lk_tag,
  input  logic                              lk_hit,
  output logic                              tag_wr_en,
  output logic [NUM_BANKS-1:0][1:0]         rd_slot,
  input  logic [NUM_BANKS-1:0][TEXEL_W-1:0] rd_data,
  output logic                              bank_wr_en,
  output logic [1:0]                        bank_wr_bank,
  output logic [1:0]                        bank_wr_slot
);

  localparam int BEAT_W = $clog2(TILE_TEXELS);

  tc_state_e                         st_q;
  logic [COORD_W-1:0]                x_q, y_q;
  logic [1:0]                        cor_q;
  logic [NUM_BANKS-1:0]              got_q;
  logic [NUM_BANKS-1:0][TEXEL_W-1:0] tex_q;
  logic [BEAT_W-1:0]                 beat_q;

  logic                              x_cross, y_cross;
  logic [3:0]                        need;
  logic [TC_W-1:0]                   tx0, ty0, ctx, cty;
  logic                              has_nxt;
  logic [1:0]                        nxt;
  logic [NUM_BANKS-1:0][TEXEL_W-1:0] tex_rd;
  logic [NUM_BANKS-1:0]              in_tile;
  logic [COORD_W-1:0]                xi, yi;
  logic                              ox, oy;
  logic                              last_beat;

  // footprint geometry
  assign x_cross = (x_q[1:0] == 2'd3);
  assign y_cross = (y_q[1:0] == 2'd3);
  assign need    = {x_cross & y_cross, y_cross, x_cross, 1'b1};
  assign tx0     = x_q[COORD_W-1:2];
  assign ty0     = y_q[COORD_W-1:2];
  assign ctx     = (cor_q[0] & x_cross) ? tx0 + 1'b1 : tx0;
  assign cty     = (cor_q[1] & y_cross) ? ty0 + 1'b1 : ty0;

  assign lk_idx  = {cty[IDX_Y_W-1:0], ctx[IDX_X_W-1:0]};
  assign lk_tag  = {cty[TC_W-1:IDX_Y_W], ctx[TC_W-1:IDX_X_W]};

  // next corner that starts a new tile
  always_comb begin
    has_nxt = 1'b0;
    nxt     = cor_q;
    for (int k = 3; k >= 0; k--) begin
      if (k > int'(cor_q) && need[k]) begin
        has_nxt = 1'b1;
        nxt     = 2'(k);
      end
    end
  end

  // steer each lane to the bank that holds it
  always_comb begin
    rd_slot = '0;
    tex_rd  = '0;
    in_tile = '0;
    xi      = '0;
    yi      = '0;
    ox      = 1'b0;
    oy      = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      xi = x_q + COORD_W'(i % 2);
      yi = y_q + COORD_W'(i / 2);
      rd_slot[bank_sel(xi[1:0], yi[1:0])] = slot_sel(xi[1:0], yi[1:0]);
      tex_rd[i] = rd_data[bank_sel(xi[1:0], yi[1:0])];
      ox = ((i % 2) == 1) && x_cross;
      oy = ((i / 2) == 1) && y_cross;
      in_tile[i] = (ox == (cor_q[0] & x_cross)) && (oy == (cor_q[1] & y_cross));
    end
  end

  // fill beat placement: raster order inside the tile
  assign last_beat    = (beat_q == BEAT_W'(TILE_TEXELS - 1));
  assign bank_wr_en   = (st_q == ST_FDATA) && fill_data_valid;
  assign bank_wr_bank = bank_sel(beat_q[1:0], beat_q[3:2]);
  assign bank_wr_slot = slot_sel(beat_q[1:0], beat_q[3:2]);
  assign tag_wr_en    = bank_wr_en && last_beat;

  assign req_ready      = (st_q == ST_IDLE);
  assign rsp_valid      = (st_q == ST_RESP);
  assign rsp_texels     = tex_q;
  assign fill_req_valid = (st_q == ST_FREQ);
  assign fill_tile_x    = ctx;
  assign fill_tile_y    = cty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      cor_q  <= '0;
      got_q  <= '0;
      tex_q  <= '0;
      beat_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            x_q   <= req_x;
            y_q   <= req_y;
            cor_q <= '0;
            got_q <= '0;
            st_q  <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          if (lk_hit) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
              if (in_tile[i]) begin
                tex_q[i] <= tex_rd[i];
                got_q[i] <= 1'b1;
              end
            end
            if (has_nxt) cor_q <= nxt;
            else         st_q  <= ST_RESP;
          end else begin
            st_q <= ST_FREQ;
          end
        end
        ST_FREQ: begin
          if (fill_req_ready) begin
            beat_q <= '0;
            st_q   <= ST_FDATA;
          end
        end
        ST_FDATA: begin
          if (fill_data_valid) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) st_q <= ST_ACCESS;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled response holds steady
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_texels));

  // R4: fill request and its tile stay put until accepted
  a_r4_fill_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_req_ready |=> fill_req_valid && $stable({fill_tile_x, fill_tile_y}));

  // R6: a response only leaves once every lane has been gathered
  a_r6_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (got_q == {NUM_BANKS{1'b1}}));

  // R5: a hit never leads into a fill request
  a_r5_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACCESS) && lk_hit |=> !fill_req_valid);

  // R8: an accepted lookup blocks the next one
  a_r8_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

endmodule

// File: rtl/tex_tile_cache.sv
module tex_tile_cache
  import tc_pkg::*;
#(
  parameter int TEXEL_W   = 32,
  parameter int COORD_W   = 12,
  parameter int NUM_LINES = 32,
  parameter int IDX_X_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     invalidate,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [COORD_W-1:0]       req_x,
  input  logic [COORD_W-1:0]       req_y,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [4*TEXEL_W-1:0]     rsp_texels,
  output logic                     fill_req_valid,
  input  logic                     fill_req_ready,
  output logic [COORD_W-3:0]       fill_tile_x,
  output logic [COORD_W-3:0]       fill_tile_y,
  input  logic                     fill_data_valid,
  input  logic [TEXEL_W-1:0]       fill_data
);

  localparam int IDX_W   = $clog2(NUM_LINES);
  localparam int IDX_Y_W = IDX_W - IDX_X_W;
  localparam int TC_W    = COORD_W - 2;
  localparam int TAG_W   = 2 * TC_W - IDX_W;

  logic [IDX_W-1:0]                  lk_idx;
  logic [TAG_W-1:0]                  lk_tag;
  logic                              lk_hit;
  logic                              tag_wr_en;
  logic [NUM_BANKS-1:0][1:0]         rd_slot;
  logic [NUM_BANKS-1:0][TEXEL_W-1:0] rd_data;
  logic                              bank_wr_en;
  logic [1:0]                        bank_wr_bank;
  logic [1:0]                        bank_wr_slot;

  tc_ctrl #(
    .TEXEL_W (TEXEL_W),
    .COORD_W (COORD_W),
    .IDX_X_W (IDX_X_W),
    .IDX_Y_W (IDX_Y_W),
    .TC_W    (TC_W),
    .IDX_W   (IDX_W),
    .TAG_W   (TAG_W)
  ) ctrl_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_x           (req_x),
    .req_y           (req_y),
    .rsp_valid       (rsp_valid),
    .rsp_ready       (rsp_ready),
    .rsp_texels      (rsp_texels),
    .fill_req_valid  (fill_req_valid),
    .fill_req_ready  (fill_req_ready),
    .fill_tile_x     (fill_tile_x),
    .fill_tile_y     (fill_tile_y),
    .fill_data_valid (fill_data_valid),
    .lk_idx          (lk_idx),
    .lk_tag          (lk_tag),
    .lk_hit          (lk_hit),
    .tag_wr_en       (tag_wr_en),
    .rd_slot         (rd_slot),
    .rd_data         (rd_data),
    .bank_wr_en      (bank_wr_en),
    .bank_wr_bank    (bank_wr_bank),
    .bank_wr_slot    (bank_wr_slot)
  );

  tc_tag_store #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .TAG_W     (TAG_W)
  ) tags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inval_i  (invalidate),
    .lk_idx_i (lk_idx),
    .lk_tag_i (lk_tag),
    .lk_hit_o (lk_hit),
    .wr_en_i  (tag_wr_en),
    .wr_idx_i (lk_idx),
    .wr_tag_i (lk_tag)
  );

  tc_bank_store #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .TEXEL_W   (TEXEL_W)
  ) banks_i (
    .clk       (clk),
    .rd_idx_i  (lk_idx),
    .rd_slot_i (rd_slot),
    .rd_data_o (rd_data),
    .wr_en_i   (bank_wr_en),
    .wr_idx_i  (lk_idx),
    .wr_bank_i (bank_wr_bank),
    .wr_slot_i (bank_wr_slot),
    .wr_data_i (fill_data)
  );

  // R1: the lookup side is open and no fill is pending out of reset
  a_r1_reset_outputs: assert property (@(posedge clk)
    !rst_n |=> req_ready && !rsp_valid && !fill_req_valid);

endmodule

// File: tb/tex_tile_cache_tb.sv
module tex_tile_cache_tb_top;

  localparam int CW = 12;
  localparam int TW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          invalidate = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_x = '0;
  logic [CW-1:0] req_y = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [4*TW-1:0] rsp_texels;
  logic          fill_req_valid;
  logic          fill_req_ready = 1'b0;
  logic [CW-3:0] fill_tile_x, fill_tile_y;
  logic          fill_data_valid = 1'b0;
  logic [TW-1:0] fill_data = '0;

  always #5 clk = ~clk;

  tex_tile_cache dut_i (
    .clk(clk), .rst_n(rst_n), .invalidate(invalidate),
    .req_valid(req_valid), .req_ready(req_ready), .req_x(req_x), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_texels(rsp_texels),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_tile_x(fill_tile_x), .fill_tile_y(fill_tile_y),
    .fill_data_valid(fill_data_valid), .fill_data(fill_data)
  );

  int nchk = 0;
  int nfail = 0;
  int fill_cnt = 0;
  logic [CW-3:0] log_tx [64];
  logic [CW-3:0] log_ty [64];

  function automatic logic [TW-1:0] tex_val(input logic [CW-1:0] x, input logic [CW-1:0] y);
    return {4'hA, x, 4'h5, y};
  endfunction

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: accepts a fill request, streams 16 beats with one idle gap
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req_ready) begin
        fill_req_ready = 1'b0;
        for (int k = 0; k < 16; k++) begin
          if (k == 5) begin
            fill_data_valid = 1'b0;
            @(negedge clk);
          end
          fill_data_valid = 1'b1;
          fill_data = tex_val(CW'({log_tx[(fill_cnt - 1) % 64], 2'(k % 4)}),
                              CW'({log_ty[(fill_cnt - 1) % 64], 2'(k / 4)}));
          @(negedge clk);
        end
        fill_data_valid = 1'b0;
      end else if (fill_req_valid) begin
        log_tx[fill_cnt % 64] = fill_tile_x;
        log_ty[fill_cnt % 64] = fill_tile_y;
        fill_cnt++;
        fill_req_ready = 1'b1;
      end
    end
  end

  // issues one lookup and waits for the response without taking it
  task automatic issue(input logic [CW-1:0] x, input logic [CW-1:0] y, output int lat, output bit busy_ok);
    int guard;
    busy_ok = 1'b1;
    req_x = x;
    req_y = y;
    req_valid = 1'b1;
    guard = 0;
    while (!req_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 400) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic logic [127:0] exp_fp(input logic [CW-1:0] x, input logic [CW-1:0] y);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      r[32*i +: 32] = tex_val(x + CW'(i % 2), y + CW'(i / 2));
    return r;
  endfunction

  typedef struct packed {
    logic [11:0] x;
    logic [11:0] y;
    logic [3:0]  nf;
    logic [9:0]  ftx;
    logic [9:0]  fty;
    logic [3:0]  lat;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{12'd0,    12'd0,    4'd1, 10'd0,    10'd0,    4'd0},  // R4 cold miss
    '{12'd1,    12'd1,    4'd0, 10'd0,    10'd0,    4'd2},  // R5 R7 hit inside tile
    '{12'd3,    12'd0,    4'd1, 10'd1,    10'd0,    4'd0},  // R6 x crossing
    '{12'd3,    12'd3,    4'd2, 10'd0,    10'd1,    4'd0},  // R6 x and y crossing
    '{12'd2,    12'd2,    4'd0, 10'd0,    10'd0,    4'd2},  // R2 lane steering
    '{12'd5,    12'd6,    4'd0, 10'd0,    10'd0,    4'd2},  // R5 hit in second tile
    '{12'd32,   12'd0,    4'd1, 10'd8,    10'd0,    4'd0},  // R3 index conflict
    '{12'd0,    12'd0,    4'd1, 10'd0,    10'd0,    4'd0},  // R3 evicted tile refetched
    '{12'd4095, 12'd4095, 4'd3, 10'd1023, 10'd1023, 4'd0},  // R2 wrap at corner
    '{12'd4094, 12'd4094, 4'd0, 10'd0,    10'd0,    4'd2},  // R5 corner tile hit
    '{12'd4095, 12'd4095, 4'd0, 10'd0,    10'd0,    4'd5},  // R7 four-tile hit
    '{12'd3,    12'd0,    4'd0, 10'd0,    10'd0,    4'd3}   // R7 two-tile hit
  };

  initial begin
    repeat (60000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lat;
    int f0;
    bit busy_ok;
    logic [127:0] held;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "req_ready", 128'(req_ready), 128'(1'b1));
    check("R1", "rsp_valid", 128'(rsp_valid), 128'(1'b0));
    check("R1", "fill_req_valid", 128'(fill_req_valid), 128'(1'b0));
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 12; v++) begin
      f0 = fill_cnt;
      issue(VECS[v].x, VECS[v].y, lat, busy_ok);
      check("R2", "texels", rsp_texels, exp_fp(VECS[v].x, VECS[v].y));
      check("R5", "fill count", 128'(fill_cnt - f0), 128'(VECS[v].nf));
      check("R8", "req_ready low while busy", 128'(busy_ok), 128'(1'b1));
      if (VECS[v].nf != 0)
        check("R6", "first fill tile", {108'd0, log_tx[f0 % 64], log_ty[f0 % 64]},
              {108'd0, VECS[v].ftx, VECS[v].fty});
      if (VECS[v].lat != 0)
        check("R7", "hit latency", 128'(lat), 128'(VECS[v].lat));
      take();
    end

    // R10 invalidate then refetch of a resident tile
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    f0 = fill_cnt;
    issue(12'd1, 12'd1, lat, busy_ok);
    check("R10", "fill after invalidate", 128'(fill_cnt - f0), 128'd1);
    check("R10", "texels after refetch", rsp_texels, exp_fp(12'd1, 12'd1));
    take();

    // R9 back-pressure on the response
    issue(12'd2, 12'd1, lat, busy_ok);
    held = rsp_texels;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", "rsp_valid held", 128'(rsp_valid), 128'(1'b1));
      check("R9", "texels held", rsp_texels, held);
      check("R8", "req_ready low while stalled", 128'(req_ready), 128'(1'b0));
    end
    check("R9", "held value", held, exp_fp(12'd2, 12'd1));
    take();
    check("R8", "req_ready after take", 128'(req_ready), 128'(1'b1));
    check("R9", "rsp_valid dropped", 128'(rsp_valid), 128'(1'b0));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule